// File: doc/BRIEF.md
# Address Security Attribution Unit

This block assigns fixed security attributes to any 32-bit address presented by a core that has separate secure and non-secure states. Each lookup returns four values: a 4-bit region number, a non-secure flag, a flag marking secure code the non-secure side may call into, and an exempt flag. Exempt ranges are ones the core handles with its own rules. Every attribute except the callable flag depends only on the top nibble of the address, or on a fixed mask compare. The callable flag for each odd (secure) region that supports it is gated by one bit of a small configuration register.

The lookup is combinational and adds no latency. Software reaches the configuration register through a plain single-cycle port made of valid, write, word address and data. The register sits at word offset 0. The unit can only tighten the attribution the core already makes and never loosens it. It has no means to mark a secure region non-secure.

Top module: `addr_sec_classifier`

## Requirements
- R1: `regionId` equals `lookupAddr[31:28]` in the same cycle.
- R2: `isNonSecure` is 1 when `lookupAddr[28]` is 0, and 0 when it is 1.
- R3: `isCallable` is 1 for region 1 only when config bit 0 is 1, and for region 3 only when config bit 1 is 1. It is 0 for every other region.
- R4: `isCallable` and `isNonSecure` are never 1 together, whatever the config value.
- R5: `isExempt` is 1 exactly when `(lookupAddr & 32'hEFF0_0000) == 32'hE000_0000`, which covers 0xE000_0000–0xE00F_FFFF and 0xF000_0000–0xF00F_FFFF.
- R6: After reset the config register reads 0, so no region is callable.
- R7: A write is accepted on a rising clock edge when `cfgValid`=1, `cfgWrite`=1 and `cfgAddr`=0. The lookup outputs use the new value from the next cycle on. In the write cycle itself they still use the old value.
- R8: Only `cfgWdata[1:0]` is stored. A read of offset 0 (`cfgValid`=1, `cfgWrite`=0, `cfgAddr`=0) returns the stored bits in `cfgRdata[1:0]`, with bits [31:2] zero, in the same cycle.
- R9: A write with `cfgValid`=0, or to any offset other than 0, leaves the register unchanged. `cfgRdata` is 0 in any cycle that is not a read of offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| lookupAddr | input | 32 | Address to classify |
| regionId | output | 4 | Region number (top address nibble) |
| isNonSecure | output | 1 | Address lies in a non-secure region |
| isCallable | output | 1 | Secure region enabled as non-secure callable |
| isExempt | output | 1 | Address lies in an exempt range |
| cfgValid | input | 1 | Config access strobe |
| cfgWrite | input | 1 | 1 = write, 0 = read |
| cfgAddr | input | 4 | Config word offset |
| cfgWdata | input | 32 | Config write data |
| cfgRdata | output | 32 | Config read data |

## Verification
The hardest case to reach is a write to the config register in the same cycle as a lookup of an affected region. There the outputs must still show the old value, and they must switch exactly one cycle later. The bench produces this case directly: it drives a lookup of region 1 or region 3 together with writes that flip the matching bit. It also drives a long random mix of lookups and accesses, including writes to the wrong offset and writes with the strobe low. A per-cycle reference model tracks the register value so that every output is compared in every cycle.

// File: rtl/sau_pkg.sv
package sau_pkg;
  typedef struct packed {
    logic wrEn;
    logic rdEn;
  } cfgStrobe_t;
endpackage

// File: rtl/sau_ctrl.sv
module sau_ctrl #(
  parameter int CFG_AW = 4,
  parameter int CFG_OFFSET = 0
) (
  input  logic              cfgValid,
  input  logic              cfgWrite,
  input  logic [CFG_AW-1:0] cfgAddr,
  output sau_pkg::cfgStrobe_t strobe
);
  localparam logic [CFG_AW-1:0] OffsetVal = CFG_AW'(CFG_OFFSET);

  logic hit;

  always_comb begin
    hit = cfgValid && (cfgAddr == OffsetVal);
    strobe.wrEn = hit && cfgWrite;
    strobe.rdEn = hit && !cfgWrite;
  end
endmodule

// File: rtl/sau_dp.sv
module sau_dp #(
  parameter int ADDR_W = 32,
  parameter int REGION_W = 4,
  parameter int CFG_DW = 32,
  parameter int NUM_CALL = 2,
  parameter logic [ADDR_W-1:0] EXEMPT_MASK = 32'hEFF0_0000,
  parameter logic [ADDR_W-1:0] EXEMPT_MATCH = 32'hE000_0000
) (
  input  logic                clk,
  input  logic                rstN,
  input  sau_pkg::cfgStrobe_t strobe,
  input  logic [NUM_CALL-1:0] wrBits,
  input  logic [ADDR_W-1:0]   lookupAddr,
  output logic [REGION_W-1:0] regionId,
  output logic                isNonSecure,
  output logic                isCallable,
  output logic                isExempt,
  output logic [CFG_DW-1:0]   cfgRdata
);
  localparam int PadW = CFG_DW - NUM_CALL;

  logic [NUM_CALL-1:0] cfgReg;
  logic [NUM_CALL-1:0] callHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgReg <= '0;
    else if (strobe.wrEn) cfgReg <= wrBits;
  end

  assign regionId    = lookupAddr[ADDR_W-1 -: REGION_W];
  assign isNonSecure = ~regionId[0];
  assign isExempt    = (lookupAddr & EXEMPT_MASK) == EXEMPT_MATCH;

  // Callable window i sits in secure region 2*i+1, gated by cfgReg[i].
  for (genvar i = 0; i < NUM_CALL; i++) begin : g_call
    assign callHit[i] = cfgReg[i] && (regionId == REGION_W'(2 * i + 1));
  end
  assign isCallable = |callHit;

  assign cfgRdata = strobe.rdEn ? {{PadW{1'b0}}, cfgReg} : '0;
endmodule

// File: rtl/addr_sec_classifier.sv
module addr_sec_classifier #(
  parameter int ADDR_W = 32,
  parameter int REGION_W = 4,
  parameter int CFG_AW = 4,
  parameter int CFG_DW = 32,
  parameter int NUM_CALL = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   lookupAddr,
  output logic [REGION_W-1:0] regionId,
  output logic                isNonSecure,
  output logic                isCallable,
  output logic                isExempt,
  input  logic                cfgValid,
  input  logic                cfgWrite,
  input  logic [CFG_AW-1:0]   cfgAddr,
  input  logic [CFG_DW-1:0]   cfgWdata,
  output logic [CFG_DW-1:0]   cfgRdata
);
  sau_pkg::cfgStrobe_t strobe;

  sau_ctrl #(.CFG_AW(CFG_AW), .CFG_OFFSET(0)) u_ctrl (
    .cfgValid(cfgValid),
    .cfgWrite(cfgWrite),
    .cfgAddr (cfgAddr),
    .strobe  (strobe)
  );

  sau_dp #(
    .ADDR_W(ADDR_W), .REGION_W(REGION_W), .CFG_DW(CFG_DW), .NUM_CALL(NUM_CALL)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrBits     (cfgWdata[NUM_CALL-1:0]),
    .lookupAddr (lookupAddr),
    .regionId   (regionId),
    .isNonSecure(isNonSecure),
    .isCallable (isCallable),
    .isExempt   (isExempt),
    .cfgRdata   (cfgRdata)
  );
endmodule

// File: rtl/sau_attr_chk.sv
module sau_attr_chk (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] lookupAddr,
  input logic [3:0]  regionId,
  input logic        isNonSecure,
  input logic        isCallable,
  input logic        isExempt,
  input logic        cfgValid,
  input logic        cfgWrite,
  input logic [3:0]  cfgAddr,
  input logic [1:0]  cfgWdataLo,
  input logic [31:0] cfgRdata
);
  logic wrAcc;
  logic rdAcc;
  assign wrAcc = cfgValid && cfgWrite && (cfgAddr == 4'd0);
  assign rdAcc = cfgValid && !cfgWrite && (cfgAddr == 4'd0);

  p_ns_from_region_r2: assert property (@(posedge clk) disable iff (!rstN)
    isNonSecure == !regionId[0]);

  p_callable_secure_r4: assert property (@(posedge clk) disable iff (!rstN)
    isCallable |-> !isNonSecure);

  p_callable_regions_r3: assert property (@(posedge clk) disable iff (!rstN)
    isCallable |-> (regionId == 4'd1 || regionId == 4'd3));

  p_exempt_top_r5: assert property (@(posedge clk) disable iff (!rstN)
    isExempt |-> (regionId == 4'hE || regionId == 4'hF));

  p_write_r1_next_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrAcc ##1 (regionId == 4'd1) |-> isCallable == $past(cfgWdataLo[0]));

  p_write_r3_next_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrAcc ##1 (regionId == 4'd3) |-> isCallable == $past(cfgWdataLo[1]));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !wrAcc ##1 $stable(lookupAddr) |-> $stable(isCallable));

  p_rdata_upper_r8: assert property (@(posedge clk) disable iff (!rstN)
    rdAcc |-> cfgRdata[31:2] == 30'd0);

  p_rdata_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !rdAcc |-> cfgRdata == 32'd0);
endmodule

bind addr_sec_classifier sau_attr_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .lookupAddr (lookupAddr),
  .regionId   (regionId),
  .isNonSecure(isNonSecure),
  .isCallable (isCallable),
  .isExempt   (isExempt),
  .cfgValid   (cfgValid),
  .cfgWrite   (cfgWrite),
  .cfgAddr    (cfgAddr),
  .cfgWdataLo (cfgWdata[1:0]),
  .cfgRdata   (cfgRdata)
);

// File: tb/addr_sec_classifier_tb.sv
module addr_sec_classifier_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] lookupAddr = '0;
  logic [3:0]  regionId;
  logic        isNonSecure, isCallable, isExempt;
  logic        cfgValid = 1'b0, cfgWrite = 1'b0;
  logic [3:0]  cfgAddr = '0;
  logic [31:0] cfgWdata = '0;
  logic [31:0] cfgRdata;

  int checks = 0;
  int fails = 0;
  int refCfg = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  addr_sec_classifier u_dut (
    .clk(clk), .rstN(rstN), .lookupAddr(lookupAddr), .regionId(regionId),
    .isNonSecure(isNonSecure), .isCallable(isCallable), .isExempt(isExempt),
    .cfgValid(cfgValid), .cfgWrite(cfgWrite), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s addr=%h act=%h exp=%h", req, lookupAddr, act, exp);
    end
  endtask

  // Drive one cycle, compare against the behavioural model, then advance it.
  task automatic step(input logic [31:0] a, input bit v, input bit w,
                      input logic [3:0] off, input logic [31:0] d);
    int reg4;
    bit expNs, expCall, expEx;
    logic [31:0] expRd;
    @(negedge clk);
    lookupAddr = a; cfgValid = v; cfgWrite = w; cfgAddr = off; cfgWdata = d;
    #1;
    reg4 = int'(a >> 28);
    expNs = (reg4 % 2) == 0;
    expCall = (reg4 == 1 && refCfg[0]) || (reg4 == 3 && refCfg[1]);
    expEx = (a & 32'hEFF0_0000) == 32'hE000_0000;
    expRd = (v && !w && off == 0) ? 32'(refCfg) : 32'd0;
    chk("R1 region", 32'(regionId), 32'(reg4));
    chk("R2 nonsecure", 32'(isNonSecure), 32'(expNs));
    chk("R3 R7 callable", 32'(isCallable), 32'(expCall));
    chk("R4 callable&ns", 32'(isCallable && isNonSecure), 32'd0);
    chk("R5 exempt", 32'(isExempt), 32'(expEx));
    chk("R8 R9 rdata", cfgRdata, expRd);
    @(posedge clk);
    if (v && w && off == 0) refCfg = int'(d & 32'h3);
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    // R6: reset value reads zero and nothing is callable
    step(32'h0, 1, 0, 0, 0);
    chk("R6 reset cfg", cfgRdata, 32'd0);
    for (int r = 0; r < 16; r++) step({r[3:0], 28'h0123456}, 0, 0, 0, 0);
    // R3: each config value, sweep every region
    for (int c = 0; c < 4; c++) begin
      step(32'h1000_0000, 1, 1, 0, 32'(c));
      for (int r = 0; r < 16; r++) step({r[3:0], 28'hFFFFFFF}, 0, 0, 0, 0);
    end
    // R7: write in the same cycle as a lookup of the affected region
    step(32'h1000_0000, 1, 1, 0, 32'h0);
    step(32'h1000_0000, 1, 1, 0, 32'h1);
    step(32'h1000_0000, 0, 0, 0, 0);
    step(32'h3000_0000, 1, 1, 0, 32'h2);
    step(32'h3000_0000, 1, 1, 0, 32'h0);
    step(32'h3000_0000, 0, 0, 0, 0);
    // R8: upper write bits dropped
    step(32'h0, 1, 1, 0, 32'hFFFF_FFFF);
    step(32'h1000_0000, 1, 0, 0, 0);
    chk("R8 readback", cfgRdata, 32'h3);
    // R9: writes to other offsets, or with valid low, are ignored
    step(32'h0, 1, 1, 4'd4, 32'h0);
    step(32'h0, 0, 1, 0, 32'h0);
    step(32'h3000_0000, 1, 0, 0, 0);
    chk("R9 ignored write", cfgRdata, 32'h3);
    step(32'h3000_0000, 1, 0, 4'd1, 0);
    // R5: exempt boundaries
    step(32'hE000_0000, 0, 0, 0, 0);
    step(32'hE00F_FFFF, 0, 0, 0, 0);
    step(32'hE010_0000, 0, 0, 0, 0);
    step(32'hDFFF_FFFF, 0, 0, 0, 0);
    step(32'hF000_0000, 0, 0, 0, 0);
    step(32'hF00F_FFFF, 0, 0, 0, 0);
    step(32'hF010_0000, 0, 0, 0, 0);
    step(32'h6000_0000, 0, 0, 0, 0);
    // Random mix
    for (int i = 0; i < 2000; i++) begin
      logic [3:0] off;
      off = ($urandom % 3 == 0) ? 4'($urandom) : 4'd0;
      step($urandom, 1'($urandom), 1'($urandom), off, $urandom);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule